// File: doc/BRIEF.md
# Super I/O Index/Data Configuration Port

This block is the configuration front end of a Super I/O controller. Software reaches it through two byte-wide I/O locations: an index port (offset 0, normally decoded at 0x3F0) and a data port (offset 1, normally at 0x3F1). A byte written to the index port chooses one of 256 configuration bytes. The data port then reads or writes the chosen byte. The index itself lives in entry 0 of the same 256-byte array. Reading entry 0 through the data port returns zero, not the index.

Only a scattered set of indices in the top bank accept data writes. Every other index is read-only, and a write to it is dropped without effect. The identification byte, the function-select byte and the base-address bytes of the floppy, parallel and two serial functions come up with fixed defaults. The whole port pair is gated by an enable input that the host bridge drives from one of its own configuration bits. While the enable is low, reads return 0xFF and writes do nothing.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the index (entry 0) is 0x00, and every entry without a listed default reads 0x00.
- R2: A write with `acc_addr`=0 loads the index from `wdata` at the clock edge. A read with `acc_addr`=0 returns the current index. A data-port write never changes the index.
- R3: A read with `acc_addr`=1 while the index is 0x00 returns 0x00. A data-port write at index 0x00 is dropped.
- R4: A data-port write (`acc_addr`=1) stores `wdata` into the entry selected by the index when that index is one of 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC.
- R5: A data-port write to any other index (0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB, 0xFD–0xFF) leaves that entry unchanged.
- R6: While `port_en` is 0, a read returns 0xFF, and index and data writes change nothing.
- R7: `rdata` is combinational. It is valid in the same cycle as `rd_stb` and reads 0x00 while `rd_stb` is low.
- R8: Reset defaults: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port pair enable from the bridge configuration bit |
| acc_addr | input | 1 | Port offset: 0 = index, 1 = data |
| wr_stb | input | 1 | Single-byte write strobe |
| rd_stb | input | 1 | Single-byte read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, same cycle as `rd_stb` |

## Verification
The hardest case to reach is a data write that lands on a read-only entry and must leave it unchanged. A dropped write and a correct write of the old value look the same at the ports. The stimulus therefore writes the complement of each index to its own entry across all 256 indices and reads it back, so every dropped write shows up as a preserved default. A reset in the middle of the run, after the writable entries have been overwritten, then shows the defaults coming back.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int unsigned SIO_IDX_W = 8;

  typedef enum logic {
    PORT_INDEX = 1'b0,
    PORT_DATA  = 1'b1
  } sio_port_e;

  // Writable entries of the configuration array (all others are read-only).
  function automatic logic sio_writable(input logic [SIO_IDX_W-1:0] idx);
    case (idx) inside
      [8'hE0:8'hE3],
      [8'hE6:8'hE8],
      [8'hEE:8'hF2],
      8'hF4, 8'hF6, 8'hF8, 8'hFC: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

  // Value an entry takes at reset.
  function automatic logic [SIO_IDX_W-1:0] sio_reset_val(input logic [SIO_IDX_W-1:0] idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
#(
  parameter int unsigned W = SIO_IDX_W
) (
  input  logic         port_en,
  input  logic         wr_stb,
  input  logic         acc_addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] idx_q,
  output logic         idx_we,
  output logic         data_we,
  output logic         wr_en,
  output logic [W-1:0] wr_addr,
  output logic [W-1:0] wr_data
);

  logic live_wr;

  assign live_wr = port_en && wr_stb;
  assign idx_we  = live_wr && (sio_port_e'(acc_addr) == PORT_INDEX);
  assign data_we = live_wr && (sio_port_e'(acc_addr) == PORT_DATA) && sio_writable(idx_q);

  // One write port: the index write targets entry 0, a data write the indexed entry.
  always_comb begin
    wr_en   = idx_we || data_we;
    wr_addr = idx_we ? '0 : idx_q;
    wr_data = wdata;
  end

endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter int unsigned W     = SIO_IDX_W,
  parameter int unsigned DEPTH = 1 << W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_addr,
  input  logic [W-1:0]     wr_data,
  output logic [DEPTH*W-1:0] mem_flat
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [W-1:0] RST_VAL = sio_reset_val(W'(g));
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= RST_VAL;
      end else if (wr_en && (wr_addr == W'(g))) begin
        q <= wr_data;
      end
    end

    assign mem_flat[g*W +: W] = q;
  end

endmodule

// File: rtl/sio_cfg_rdmux.sv
module sio_cfg_rdmux
  import sio_cfg_pkg::*;
#(
  parameter int unsigned W     = SIO_IDX_W,
  parameter int unsigned DEPTH = 1 << W
) (
  input  logic               port_en,
  input  logic               rd_stb,
  input  logic               acc_addr,
  input  logic [W-1:0]       idx_q,
  input  logic [DEPTH*W-1:0] mem_flat,
  output logic [W-1:0]       rd_word,
  output logic [W-1:0]       rdata
);

  assign rd_word = mem_flat[idx_q*W +: W];

  always_comb begin
    if (!rd_stb) begin
      rdata = '0;
    end else if (!port_en) begin
      rdata = '1;
    end else if (sio_port_e'(acc_addr) == PORT_INDEX) begin
      rdata = idx_q;
    end else if (idx_q == '0) begin
      rdata = '0;
    end else begin
      rdata = rd_word;
    end
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned W = SIO_IDX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         port_en,
  input  logic         acc_addr,
  input  logic         wr_stb,
  input  logic         rd_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << W;

  logic               idx_we;
  logic               data_we;
  logic               wr_en;
  logic [W-1:0]       wr_addr;
  logic [W-1:0]       wr_data;
  logic [DEPTH*W-1:0] mem_flat;
  logic [W-1:0]       idx_q;
  logic [W-1:0]       rd_word;

  // Entry 0 of the array is the index register.
  assign idx_q = mem_flat[W-1:0];

  sio_cfg_decode #(.W(W)) u_decode (
    .port_en (port_en),
    .wr_stb  (wr_stb),
    .acc_addr(acc_addr),
    .wdata   (wdata),
    .idx_q   (idx_q),
    .idx_we  (idx_we),
    .data_we (data_we),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  sio_cfg_regfile #(.W(W), .DEPTH(DEPTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mem_flat(mem_flat)
  );

  sio_cfg_rdmux #(.W(W), .DEPTH(DEPTH)) u_rdmux (
    .port_en (port_en),
    .rd_stb  (rd_stb),
    .acc_addr(acc_addr),
    .idx_q   (idx_q),
    .mem_flat(mem_flat),
    .rd_word (rd_word),
    .rdata   (rdata)
  );

endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         port_en,
  input logic         acc_addr,
  input logic         wr_stb,
  input logic         rd_stb,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [W-1:0] idx_q,
  input logic [W-1:0] rd_word,
  input logic         idx_we,
  input logic         data_we
);

  assert_disabled_reads_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && rd_stb) |-> (rdata == '1));

  assert_disabled_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && wr_stb) |=> $stable(idx_q));

  assert_disabled_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (!idx_we && !data_we));

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && wr_stb && !acc_addr) |=> (idx_q == $past(wdata)));

  assert_index_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && rd_stb && !acc_addr) |-> (rdata == idx_q));

  assert_data_keeps_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && wr_stb && acc_addr) |=> $stable(idx_q));

  assert_zero_index_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && rd_stb && acc_addr && idx_q == '0) |-> (rdata == '0));

  assert_writable_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && wr_stb && acc_addr && idx_q >= 8'hEE && idx_q <= 8'hF2)
    |=> (rd_word == $past(wdata)));

  assert_low_bank_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && rd_stb && acc_addr && idx_q < 8'hE0) |-> (rdata == '0));

  assert_idle_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> (rdata == '0));

endmodule

bind sio_cfg_port sio_cfg_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .port_en (port_en),
  .acc_addr(acc_addr),
  .wr_stb  (wr_stb),
  .rd_stb  (rd_stb),
  .wdata   (wdata),
  .rdata   (rdata),
  .idx_q   (idx_q),
  .rd_word (rd_word),
  .idx_we  (idx_we),
  .data_we (data_we)
);

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0;
  logic       acc_addr = 1'b0;
  logic       wr_stb = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sio_cfg_port i_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .acc_addr(acc_addr),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata)
  );

  // Bench's own view of the spec: read-only list, then defaults.
  function automatic bit read_only(input int i);
    return (i < 'hE0) || (i == 'hE4) || (i == 'hE5) || (i >= 'hE9 && i <= 'hED) ||
           (i == 'hF3) || (i == 'hF5) || (i == 'hF7) || (i >= 'hF9 && i <= 'hFB) ||
           (i >= 'hFD);
  endfunction

  function automatic logic [7:0] dflt(input int i);
    logic [7:0] v;
    v = 8'h00;
    if (i == 'hE8) v = 8'hBE;
    if (i == 'hE7) v = 8'hFE;
    if (i == 'hE6) v = 8'hDE;
    if (i == 'hE3) v = 8'hFC;
    if (i == 'hE2) v = 8'h03;
    if (i == 'hE0) v = 8'h3C;
    return v;
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    acc_addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // Read sampled in the same cycle as the strobe (R7).
  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    acc_addr = a; rd_stb = 1'b1;
    #1 d = rdata;
    rd_stb = 1'b0;
  endtask

  // Vector: {is_read, addr, data/expected, req number}
  localparam int NV = 26;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hE7, 4'd2}, {1'b1, 1'b0, 8'hE7, 4'd2},   // R2 index load/readback
    {1'b1, 1'b1, 8'hFE, 4'd8},                              // R8 serial 1 default
    {1'b0, 1'b1, 8'h55, 4'd4}, {1'b1, 1'b1, 8'h55, 4'd4},   // R4 writable
    {1'b0, 1'b0, 8'hE4, 4'd5}, {1'b0, 1'b1, 8'hAA, 4'd5},
    {1'b1, 1'b1, 8'h00, 4'd5},                              // R5 read-only E4
    {1'b0, 1'b0, 8'h00, 4'd3}, {1'b0, 1'b1, 8'h5A, 4'd3},
    {1'b1, 1'b1, 8'h00, 4'd3}, {1'b1, 1'b0, 8'h00, 4'd3},   // R3 index 0
    {1'b0, 1'b0, 8'hE0, 4'd8}, {1'b1, 1'b1, 8'h3C, 4'd8},   // R8 ident
    {1'b0, 1'b0, 8'hE1, 4'd4}, {1'b0, 1'b1, 8'h12, 4'd4},
    {1'b1, 1'b1, 8'h12, 4'd4},                              // R4 E1
    {1'b0, 1'b0, 8'h10, 4'd5}, {1'b0, 1'b1, 8'h77, 4'd5},
    {1'b1, 1'b1, 8'h00, 4'd5},                              // R5 low bank
    {1'b0, 1'b0, 8'hFC, 4'd4}, {1'b0, 1'b1, 8'hC3, 4'd4},
    {1'b1, 1'b1, 8'hC3, 4'd4},                              // R4 FC
    {1'b0, 1'b0, 8'hFD, 4'd5}, {1'b0, 1'b1, 8'h99, 4'd5},
    {1'b1, 1'b1, 8'h00, 4'd5}                               // R5 FD
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: disabled after reset, reads 0xFF, writes ignored
    bus_rd(1'b0, d); check(d, 8'hFF, "R6 disabled index read");
    bus_rd(1'b1, d); check(d, 8'hFF, "R6 disabled data read");
    bus_wr(1'b0, 8'hE1);
    port_en = 1'b1;
    // R1: index reset to 0, disabled index write had no effect
    bus_rd(1'b0, d); check(d, 8'h00, "R1/R6 index after reset");
    // R7: idle output
    #1 check(rdata, 8'h00, "R7 idle rdata");

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][13]) begin
        bus_rd(VEC[v][12], d);
        check(d, VEC[v][11:4], $sformatf("R%0d vector %0d", VEC[v][3:0], v));
      end else begin
        bus_wr(VEC[v][12], VEC[v][11:4]);
      end
    end

    // R6: disabled data write to a writable entry is dropped
    bus_wr(1'b0, 8'hEE);
    bus_wr(1'b1, 8'h11);
    port_en = 1'b0;
    bus_wr(1'b1, 8'h66);
    bus_wr(1'b0, 8'h20);
    port_en = 1'b1;
    bus_rd(1'b0, d); check(d, 8'hEE, "R6 index kept while disabled");
    bus_rd(1'b1, d); check(d, 8'h11, "R6 data kept while disabled");

    // R4/R5 sweep: write complement of index into every entry
    for (int i = 0; i < 256; i++) begin
      logic [7:0] e;
      bus_wr(1'b0, 8'(i));
      bus_wr(1'b1, ~8'(i));
      bus_rd(1'b1, d);
      if (i == 0) e = 8'h00;
      else if (read_only(i)) e = dflt(i);
      else e = ~8'(i);
      check(d, e, read_only(i) ? $sformatf("R5 sweep idx %02h", i)
                               : $sformatf("R4 sweep idx %02h", i));
      bus_rd(1'b0, d); check(d, 8'(i), "R2 index kept by data write");
    end

    // R1/R8: mid-run reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    bus_rd(1'b0, d); check(d, 8'h00, "R1 index after second reset");
    for (int i = 'hE0; i <= 'hE8; i++) begin
      bus_wr(1'b0, 8'(i));
      bus_rd(1'b1, d);
      check(d, dflt(i), $sformatf("R8/R1 default idx %02h", i));
    end
    bus_wr(1'b0, 8'hF0);
    bus_rd(1'b1, d); check(d, 8'h00, "R1 writable entry cleared by reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule